// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block takes the operands of one load or store and works out two things. The first is the address the memory access uses. The second is the value the base register should hold once the instruction completes. The base value can be combined with one of two offsets: a zero-extended immediate, or a register value passed through a barrel shifter. The offset is either added to the base or subtracted from it.

Two indexing orders are supported:
- **Pre-indexed:** the access uses the combined address, and the base register is rewritten only on request.
- **Post-indexed:** the access uses the untouched base, and the base is always advanced afterwards.

The offset forms that are legal depend on the transfer size class. When an operand combination is not allowed, the block raises an illegal flag and suppresses the base write.

The arithmetic is purely combinational. A parameter can add one register stage at the outputs.

Top module: `ldst_addr_gen`

## Requirements
- R1: In pre-indexed mode (`post_i`=0), `ea_o` equals `base_i` plus or minus the selected offset, computed modulo 2^32.
- R2: In pre-indexed mode with a legal encoding, `base_we_o` equals `wb_i`. `base_new_o` equals `ea_o` when `wb_i`=1, and equals `base_i` when `wb_i`=0.
- R3: In post-indexed mode (`post_i`=1), `ea_o` equals `base_i` and `base_new_o` equals `base_i` plus or minus the offset. `base_we_o` is 1 whenever the encoding is legal.
- R4: For size classes word (`size_i`=0) and unsigned byte (`size_i`=1), the immediate offset is all 12 bits of `imm_i`, zero-extended.
- R5: For size classes halfword (`size_i`=2) and signed (`size_i`=3), the immediate offset is `imm_i[7:0]`. Any nonzero bit in `imm_i[11:8]` raises `illegal_o`.
- R6: For size classes 2 and 3, a register offset (`use_reg_i`=1) with a nonzero `sh_amt_i` raises `illegal_o`. An unshifted register offset is legal. For size classes 0 and 1, a shifted register offset is legal.
- R7: `sub_i`=1 subtracts the offset instead of adding it, for both immediate and register offsets, modulo 2^32.
- R8: The register offset is shifted according to `sh_type_i`:
  - 0: logical left
  - 1: logical right
  - 2: arithmetic right
  - 3: rotate right
  
  The shift amount is `sh_amt_i`. An amount of 0 leaves the register unchanged for every type.
- R9: Whenever `illegal_o` is 1, `base_we_o` is 0.
- R10: With `REG_OUT`=1, the outputs show the result of the inputs one clock later. While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low reset |
| base_i | input | 32 | Base register value |
| use_reg_i | input | 1 | 1 selects the register offset, 0 selects the immediate |
| imm_i | input | 12 | Immediate offset |
| roff_i | input | 32 | Register offset value |
| sh_type_i | input | 2 | Shift type for the register offset |
| sh_amt_i | input | 5 | Shift amount for the register offset |
| sub_i | input | 1 | 1 subtracts the offset |
| post_i | input | 1 | 1 selects post-indexed, 0 selects pre-indexed |
| wb_i | input | 1 | Writeback request for pre-indexed mode |
| size_i | input | 2 | Size class: 0 word, 1 unsigned byte, 2 halfword, 3 signed |
| ea_o | output | 32 | Effective address |
| base_new_o | output | 32 | Updated base value |
| base_we_o | output | 1 | Base register write enable |
| illegal_o | output | 1 | Illegal operand combination |

## Verification
The assertions assume the inputs are known (non-X) on every clock edge once reset is released. The address and base outputs are defined only for legal encodings, and the assertions check those outputs only when `illegal_o` is low.

The bench drives one fully specified operand set per cycle and holds it stable between falling edges. Each illegal vector is scored on `illegal_o` and `base_we_o` alone. The bench also covers:
- wraparound in both the add and the subtract direction;
- every shift type, including a zero amount.

// File: rtl/ldst_ag_pkg.sv
package ldst_ag_pkg;
   typedef enum logic [1:0] {
      SZ_WORD   = 2'd0,
      SZ_UBYTE  = 2'd1,
      SZ_HALF   = 2'd2,
      SZ_SIGNED = 2'd3
   } size_cls_e;

   typedef enum logic [1:0] {
      SH_LSL = 2'd0,
      SH_LSR = 2'd1,
      SH_ASR = 2'd2,
      SH_ROR = 2'd3
   } shift_e;

   function automatic logic is_narrow(input logic [1:0] sz);
      return (sz == SZ_HALF) || (sz == SZ_SIGNED);
   endfunction
endpackage

// File: rtl/ldst_shifter.sv
module ldst_shifter #(
   parameter int AW  = 32,
   parameter int SHW = 5
) (
   input  logic [AW-1:0]  val_i,
   input  logic [1:0]     type_i,
   input  logic [SHW-1:0] amt_i,
   output logic [AW-1:0]  val_o
);
   import ldst_ag_pkg::*;

   logic [2*AW-1:0] dbl;

   assign dbl = {val_i, val_i} >> amt_i;

   always_comb begin
      unique case (shift_e'(type_i))
         SH_LSL:  val_o = val_i << amt_i;
         SH_LSR:  val_o = val_i >> amt_i;
         SH_ASR:  val_o = AW'($signed(val_i) >>> amt_i);
         default: val_o = dbl[AW-1:0];
      endcase
   end
endmodule

// File: rtl/ldst_offset_sel.sv
module ldst_offset_sel #(
   parameter int AW     = 32,
   parameter int IMM_W  = 12,
   parameter int NARW_W = 8,
   parameter int SHW    = 5
) (
   input  logic [1:0]       size_i,
   input  logic             use_reg_i,
   input  logic [IMM_W-1:0] imm_i,
   input  logic [AW-1:0]    shifted_i,
   input  logic [SHW-1:0]   sh_amt_i,
   output logic [AW-1:0]    offset_o,
   output logic             illegal_o
);
   import ldst_ag_pkg::*;

   localparam int HI_W = IMM_W - NARW_W;

   logic narrow;
   logic imm_hi_set;
   logic reg_shifted;

   assign narrow      = is_narrow(size_i);
   assign imm_hi_set  = |imm_i[IMM_W-1:NARW_W];
   assign reg_shifted = |sh_amt_i;

   always_comb begin
      if (use_reg_i)
         offset_o = shifted_i;
      else if (narrow)
         offset_o = AW'(imm_i[NARW_W-1:0]);
      else
         offset_o = AW'(imm_i);
   end

   assign illegal_o = narrow && (use_reg_i ? reg_shifted : imm_hi_set);

   if (HI_W < 1) begin : g_bad_width
      initial $error("IMM_W must exceed NARW_W");
   end
endmodule

// File: rtl/ldst_index_core.sv
module ldst_index_core #(
   parameter int AW = 32
) (
   input  logic [AW-1:0] base_i,
   input  logic [AW-1:0] offset_i,
   input  logic          sub_i,
   input  logic          post_i,
   input  logic          wb_i,
   input  logic          illegal_i,
   output logic [AW-1:0] ea_o,
   output logic [AW-1:0] base_new_o,
   output logic          base_we_o
);
   logic [AW-1:0] moved;

   assign moved      = sub_i ? (base_i - offset_i) : (base_i + offset_i);
   assign ea_o       = post_i ? base_i : moved;
   assign base_new_o = (post_i || wb_i) ? moved : base_i;
   assign base_we_o  = !illegal_i && (post_i || wb_i);
endmodule

// File: rtl/ldst_addr_gen.sv
module ldst_addr_gen #(
   parameter int AW      = 32,
   parameter int IMM_W   = 12,
   parameter int NARW_W  = 8,
   parameter int SHW     = 5,
   parameter bit REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AW-1:0]    base_i,
   input  logic             use_reg_i,
   input  logic [IMM_W-1:0] imm_i,
   input  logic [AW-1:0]    roff_i,
   input  logic [1:0]       sh_type_i,
   input  logic [SHW-1:0]   sh_amt_i,
   input  logic             sub_i,
   input  logic             post_i,
   input  logic             wb_i,
   input  logic [1:0]       size_i,
   output logic [AW-1:0]    ea_o,
   output logic [AW-1:0]    base_new_o,
   output logic             base_we_o,
   output logic             illegal_o
);
   import ldst_ag_pkg::*;

   if ((1 << SHW) > AW) begin : g_bad_shw
      initial $error("SHW too large for AW");
   end
   if (IMM_W > AW) begin : g_bad_imm
      initial $error("IMM_W must not exceed AW");
   end

   logic [AW-1:0] shifted_c, offset_c, ea_c, base_new_c;
   logic          illegal_c, base_we_c;

   ldst_shifter #(.AW(AW), .SHW(SHW)) u_shift (
      .val_i(roff_i), .type_i(sh_type_i), .amt_i(sh_amt_i), .val_o(shifted_c)
   );

   ldst_offset_sel #(.AW(AW), .IMM_W(IMM_W), .NARW_W(NARW_W), .SHW(SHW)) u_osel (
      .size_i(size_i), .use_reg_i(use_reg_i), .imm_i(imm_i),
      .shifted_i(shifted_c), .sh_amt_i(sh_amt_i),
      .offset_o(offset_c), .illegal_o(illegal_c)
   );

   ldst_index_core #(.AW(AW)) u_core (
      .base_i(base_i), .offset_i(offset_c), .sub_i(sub_i), .post_i(post_i),
      .wb_i(wb_i), .illegal_i(illegal_c), .ea_o(ea_c),
      .base_new_o(base_new_c), .base_we_o(base_we_c)
   );

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ea_o       <= '0;
            base_new_o <= '0;
            base_we_o  <= 1'b0;
            illegal_o  <= 1'b0;
         end else begin
            ea_o       <= ea_c;
            base_new_o <= base_new_c;
            base_we_o  <= base_we_c;
            illegal_o  <= illegal_c;
         end
      end
   end else begin : g_comb
      assign ea_o       = ea_c;
      assign base_new_o = base_new_c;
      assign base_we_o  = base_we_c;
      assign illegal_o  = illegal_c;
   end

   assert_no_we_when_illegal_R9: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_c |-> !base_we_c);

   assert_post_uses_base_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (post_i && !illegal_c) |-> (ea_c == base_i && base_we_c));

   assert_pre_no_wb_keeps_base_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!post_i && !wb_i) |-> (base_new_c == base_i && !base_we_c));

   assert_pre_wb_follows_ea_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!post_i && wb_i && !illegal_c) |-> (base_new_c == ea_c && base_we_c));

   assert_narrow_shift_illegal_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (is_narrow(size_i) && use_reg_i && sh_amt_i != '0) |-> illegal_c);

   if (REG_OUT) begin : g_lat_chk
      assert_one_cycle_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) |-> (illegal_o == $past(illegal_c) && base_we_o == $past(base_we_c)));
   end
endmodule

// File: tb/ldst_addr_gen_test.sv
module ldst_addr_gen_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] base_i = '0, roff_i = '0;
   logic        use_reg_i = 1'b0, sub_i = 1'b0, post_i = 1'b0, wb_i = 1'b0;
   logic [11:0] imm_i = '0;
   logic [1:0]  sh_type_i = '0, size_i = '0;
   logic [4:0]  sh_amt_i = '0;
   logic [31:0] ea_o, base_new_o;
   logic        base_we_o, illegal_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   typedef struct {
      string       tag;
      bit          chk_addr;
      logic [31:0] ea;
      logic [31:0] bn;
      logic        we;
      logic        ill;
   } exp_t;

   exp_t sb[$];

   always #5 clk = ~clk;

   ldst_addr_gen uut (
      .clk(clk), .rst_n(rst_n), .base_i(base_i), .use_reg_i(use_reg_i),
      .imm_i(imm_i), .roff_i(roff_i), .sh_type_i(sh_type_i), .sh_amt_i(sh_amt_i),
      .sub_i(sub_i), .post_i(post_i), .wb_i(wb_i), .size_i(size_i),
      .ea_o(ea_o), .base_new_o(base_new_o), .base_we_o(base_we_o), .illegal_o(illegal_o)
   );

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=0x%08h expected=0x%08h", tag, what, act, exp);
      end
   endtask

   task automatic drive(input string tag, input logic [1:0] sz, input logic ur,
                        input logic [11:0] imm, input logic [31:0] base, input logic [31:0] roff,
                        input logic [1:0] st, input logic [4:0] sa, input logic sb_, input logic po,
                        input logic wb, input bit ca, input logic [31:0] ea, input logic [31:0] bn,
                        input logic we, input logic ill);
      exp_t e;
      @(negedge clk);
      size_i = sz; use_reg_i = ur; imm_i = imm; base_i = base; roff_i = roff;
      sh_type_i = st; sh_amt_i = sa; sub_i = sb_; post_i = po; wb_i = wb;
      e.tag = tag; e.chk_addr = ca; e.ea = ea; e.bn = bn; e.we = we; e.ill = ill;
      sb.push_back(e);
   endtask

   // monitor: one cycle after capture edge
   always @(posedge clk) begin
      #1;
      if (rst_n && sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         chk(e.tag, "illegal", {31'd0, illegal_o}, {31'd0, e.ill});
         chk(e.tag, "base_we", {31'd0, base_we_o}, {31'd0, e.we});
         if (e.chk_addr) begin
            chk(e.tag, "ea", ea_o, e.ea);
            chk(e.tag, "base_new", base_new_o, e.bn);
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      chk("R10", "ea reset", ea_o, 32'h0);
      chk("R10", "base_new reset", base_new_o, 32'h0);
      chk("R10", "we/ill reset", {30'd0, base_we_o, illegal_o}, 32'h0);
      rst_n = 1'b1;
      // tag  sz ur imm base roff st sa sub post wb ca ea bn we ill
      drive("R1",  2'd0, 0, 12'h008, 32'h1000_0008, 0, 0, 0, 0, 0, 0, 1, 32'h1000_0010, 32'h1000_0008, 0, 0);
      drive("R2",  2'd0, 0, 12'h008, 32'h1000_0008, 0, 0, 0, 0, 0, 1, 1, 32'h1000_0010, 32'h1000_0010, 1, 0);
      drive("R3",  2'd1, 0, 12'h004, 32'h0000_8000, 0, 0, 0, 0, 1, 0, 1, 32'h0000_8000, 32'h0000_8004, 1, 0);
      drive("R4",  2'd1, 0, 12'hF1A, 32'h0000_1000, 0, 0, 0, 0, 0, 0, 1, 32'h0000_1F1A, 32'h0000_1000, 0, 0);
      drive("R5",  2'd2, 0, 12'h0F4, 32'h0000_0100, 0, 0, 0, 0, 0, 1, 1, 32'h0000_01F4, 32'h0000_01F4, 1, 0);
      drive("R5",  2'd2, 0, 12'h1F4, 32'h0000_0100, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 1);
      drive("R6",  2'd3, 1, 12'h000, 32'h0000_0100, 32'h2, 2'd0, 5'd2, 0, 0, 1, 0, 0, 0, 0, 1);
      drive("R6",  2'd2, 1, 12'h000, 32'h0000_0200, 32'h10, 2'd0, 5'd0, 0, 0, 1, 1, 32'h0000_0210, 32'h0000_0210, 1, 0);
      drive("R6",  2'd0, 1, 12'h000, 32'h0000_0000, 32'h3, 2'd0, 5'd28, 0, 0, 0, 1, 32'h3000_0000, 32'h0000_0000, 0, 0);
      drive("R7",  2'd0, 0, 12'h008, 32'h1000_0010, 0, 0, 0, 1, 0, 0, 1, 32'h1000_0008, 32'h1000_0010, 0, 0);
      drive("R7",  2'd0, 1, 12'h000, 32'h0000_0100, 32'h2, 2'd0, 5'd2, 1, 0, 1, 1, 32'h0000_00F8, 32'h0000_00F8, 1, 0);
      drive("R1",  2'd0, 0, 12'h008, 32'hFFFF_FFFC, 0, 0, 0, 0, 0, 0, 1, 32'h0000_0004, 32'hFFFF_FFFC, 0, 0);
      drive("R7",  2'd0, 0, 12'h008, 32'h0000_0004, 0, 0, 0, 1, 0, 1, 1, 32'hFFFF_FFFC, 32'hFFFF_FFFC, 1, 0);
      drive("R8",  2'd0, 1, 12'h000, 32'h0, 32'h8000_0000, 2'd1, 5'd4, 0, 0, 0, 1, 32'h0800_0000, 32'h0, 0, 0);
      drive("R8",  2'd0, 1, 12'h000, 32'h0, 32'h8000_0000, 2'd2, 5'd4, 0, 0, 0, 1, 32'hF800_0000, 32'h0, 0, 0);
      drive("R8",  2'd1, 1, 12'h000, 32'h0, 32'h0000_003F, 2'd3, 5'd6, 0, 0, 0, 1, 32'hFC00_0000, 32'h0, 0, 0);
      drive("R8",  2'd0, 1, 12'h000, 32'h0, 32'h1234_5678, 2'd3, 5'd0, 0, 0, 0, 1, 32'h1234_5678, 32'h0, 0, 0);
      drive("R8",  2'd0, 1, 12'h000, 32'h0, 32'h8765_4321, 2'd2, 5'd0, 0, 0, 0, 1, 32'h8765_4321, 32'h0, 0, 0);
      drive("R3",  2'd2, 1, 12'h000, 32'h0000_0500, 32'h8, 2'd0, 5'd0, 1, 1, 0, 1, 32'h0000_0500, 32'h0000_04F8, 1, 0);
      drive("R9",  2'd3, 0, 12'h100, 32'h0000_0500, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 1);
      drive("R9",  2'd2, 1, 12'h000, 32'h0000_0500, 32'h1, 2'd3, 5'd1, 0, 1, 1, 0, 0, 0, 0, 1);
      drive("R10", 2'd0, 0, 12'h001, 32'h0000_0010, 0, 0, 0, 0, 1, 0, 1, 32'h0000_0010, 32'h0000_0011, 1, 0);
      repeat (3) @(negedge clk);
      done = 1'b1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 5000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=completion");
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule